// File: doc/BRIEF.md
# Nested Prioritized Exception Controller

This block decides which exception or interrupt a single processor core services next. It tracks every source through four service states: inactive, pending, active, and active with a fresh request queued. It picks the most urgent pending source that is allowed to preempt the code now running. It then pulses an entry strobe with the vector number to take. A pulse on the handler-done input ends the current handler. If another eligible source is waiting at that moment, the controller enters it straight away and flags the entry as a tail-chain.

There are two fixed-priority sources: a non-maskable interrupt line and a hard-fault line. Both rank above every programmable level. The programmable sources each carry an enable bit and a 3-bit priority, where a lower value is more urgent. A group setting splits each priority into a preemption field and a subpriority field. Only the preemption field decides whether a source may interrupt a running handler. Saving state, fetching the vector and the software-visible registers belong to the surrounding core.

Top module: `exc_nest_ctrl`

## Requirements
- R1: After reset every source is inactive, entry_o and tail_chain_o are 0, and exec_prio_o reads 15 (thread level, nothing active).
- R2: A high request line or a set-pending strobe makes a source pending at the next clock edge. The same applies when the source is already active, which leaves it active and pending.
- R3: A clear-pending strobe removes a pending request. When set-pending and clear-pending arrive in the same cycle, set-pending wins.
- R4: A programmable source whose enable bit is 0 is never entered, but its pending state is kept. The NMI and hard-fault sources have no enable.
- R5: Fixed urgency order is NMI, then hard fault, then programmable level 0. Vector numbers are 2 for NMI, 3 for hard fault and 4+k for programmable source k.
- R6: exec_prio_o is the preemption level of the most urgent active source: 1 for NMI, 2 for hard fault, (prio >> g) + 3 for a programmable source, and 15 when none is active. A pending source is entered only if its level is strictly below exec_prio_o.
- R7: With g = min(group, 3), the low g priority bits are the subpriority. Among eligible pending sources, the lowest preemption level wins, then the lowest subpriority, then the lowest source index.
- R8: Handlers nest, and a preempted handler stays active. handler_done_i retires the active source with the most urgent level, so exec_prio_o returns to the level of the handler it interrupted.
- R9: When handler_done_i retires a handler and an eligible pending source beats the level that remains, that source is entered at the same edge. entry_o and tail_chain_o are then both 1, and tail_chain_o is never 1 without entry_o.
- R10: A source that is active and pending when it retires becomes pending and can be tail-chained back into at the same edge. While it is still active, its own queued request does not preempt it.
- R11: entry_o, vector_o and tail_chain_o are registered. They are valid for the one cycle that follows the edge at which the source becomes active, and at most one source is entered per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | NUM_IRQ (62) | Per-source request lines, sampled each edge |
| irq_en_i | input | NUM_IRQ (62) | Per-source enable |
| irq_prio_i | input | NUM_IRQ*PRIO_W (186) | Priority of source k in bits [3k+2:3k] |
| prio_group_i | input | 2 | Number of low priority bits used as subpriority (clamped to 3) |
| nmi_i | input | 1 | Non-maskable interrupt request |
| hard_fault_i | input | 1 | Hard-fault request |
| set_pend_i | input | 64 | Set-pending strobes: bit 0 NMI, bit 1 hard fault, bit k+2 source k |
| clr_pend_i | input | 64 | Clear-pending strobes, same bit layout |
| handler_done_i | input | 1 | Current handler finished |
| entry_o | output | 1 | Handler entry pulse |
| vector_o | output | 7 | Vector number of the entered source |
| tail_chain_o | output | 1 | Entry came straight from a handler return |
| exec_prio_o | output | 4 | Current execution priority level |

## Verification
A table of two-source contests covers the arbitration order under every group setting. Each row is built so that one tie-break alone decides the winner: preemption level, subpriority, or source index. Each row then retires the winner, which shows that the loser was held back rather than dropped, and that it re-enters as a tail-chain. Directed sequences set the three fixed-rank sources against each other and hold a source back while it is disabled. They also cross clear-pending with set-pending, which separates discarding a request from deferring it. A nesting run places an equal-level request next to a more urgent one, which separates strictly-more-urgent preemption from greater-or-equal. A request re-raised during its own handler checks the active-and-pending return.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned FIXED_SLOTS   = 2;
  localparam int unsigned VEC_OFFSET    = 2;
  localparam int unsigned LVL_NMI       = 1;
  localparam int unsigned LVL_HARDFAULT = 2;
  localparam int unsigned LVL_PROG_BASE = 3;

  // bit 1: active, bit 0: pending
  typedef enum logic [1:0] {
    ST_INACTIVE = 2'b00,
    ST_PENDING  = 2'b01,
    ST_ACTIVE   = 2'b10,
    ST_ACT_PEND = 2'b11
  } exc_state_e;
endpackage

// File: rtl/exc_slot_fsm.sv
module exc_slot_fsm
  import exc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic clr_i,
  input  logic take_i,
  input  logic retire_i,
  output logic pend_o,
  output logic act_o
);
  exc_state_e st_q, st_d;
  logic pend_n, act_n;

  assign pend_o = (st_q == ST_PENDING) || (st_q == ST_ACT_PEND);
  assign act_o  = (st_q == ST_ACTIVE)  || (st_q == ST_ACT_PEND);

  always_comb begin
    pend_n = req_i || (pend_o && !clr_i && !take_i);
    act_n  = take_i || (act_o && !retire_i);
    st_d   = exc_state_e'({act_n, pend_n});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_INACTIVE;
    else         st_q <= st_d;
  end

  AST_TAKE_FROM_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> pend_o); // R6
  AST_RETIRE_FROM_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i |-> act_o); // R8
  AST_REQ_PENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> pend_o); // R2
endmodule

// File: rtl/exc_level_map.sv
module exc_level_map
  import exc_pkg::*;
#(
  parameter int NUM_IRQ = 62,
  parameter int PRIO_W  = 3,
  parameter int LVL_W   = 4,
  parameter int GRP_W   = 2,
  localparam int NSLOT  = NUM_IRQ + FIXED_SLOTS
) (
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
  input  logic [GRP_W-1:0]          group_i,
  output logic [NSLOT*LVL_W-1:0]    lvl_o,
  output logic [NSLOT*PRIO_W-1:0]   sub_o
);
  logic [GRP_W-1:0]  sub_bits;
  logic [PRIO_W-1:0] sub_mask;

  assign sub_bits = (32'(group_i) > PRIO_W) ? GRP_W'(PRIO_W) : group_i;
  assign sub_mask = PRIO_W'((1 << sub_bits) - 1);

  assign lvl_o[0 +: LVL_W]     = LVL_W'(LVL_NMI);
  assign lvl_o[LVL_W +: LVL_W] = LVL_W'(LVL_HARDFAULT);
  assign sub_o[0 +: 2*PRIO_W]  = '0;

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_prog
    logic [PRIO_W-1:0] p;
    assign p = prio_i[k*PRIO_W +: PRIO_W];
    assign lvl_o[(k+FIXED_SLOTS)*LVL_W +: LVL_W] =
      LVL_W'(p >> sub_bits) + LVL_W'(LVL_PROG_BASE);
    assign sub_o[(k+FIXED_SLOTS)*PRIO_W +: PRIO_W] = p & sub_mask;
  end
endmodule

// File: rtl/exc_min_select.sv
module exc_min_select #(
  parameter int N      = 4,
  parameter int KEY_W  = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]       valid_i,
  input  logic [N*KEY_W-1:0] key_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [KEY_W-1:0] best;
  logic [KEY_W-1:0] cand;

  // strict compare keeps the lowest index on equal keys
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best    = '0;
    cand    = '0;
    for (int i = 0; i < N; i++) begin
      cand = key_i[i*KEY_W +: KEY_W];
      if (valid_i[i] && (!found_o || cand < best)) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
        best    = cand;
      end
    end
  end
endmodule

// File: rtl/exc_nest_ctrl.sv
module exc_nest_ctrl
  import exc_pkg::*;
#(
  parameter int NUM_IRQ  = 62,
  parameter int PRIO_W   = 3,
  localparam int NSLOT   = NUM_IRQ + FIXED_SLOTS,
  localparam int IDX_W   = $clog2(NSLOT),
  localparam int LVL_W   = $clog2((1 << PRIO_W) + 4),
  localparam int GRP_W   = $clog2(PRIO_W + 1),
  localparam int VEC_W   = $clog2(NSLOT + VEC_OFFSET),
  localparam int MAX_NEST = (1 << PRIO_W) + FIXED_SLOTS
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_IRQ-1:0]        irq_i,
  input  logic [NUM_IRQ-1:0]        irq_en_i,
  input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio_i,
  input  logic [GRP_W-1:0]          prio_group_i,
  input  logic                      nmi_i,
  input  logic                      hard_fault_i,
  input  logic [NSLOT-1:0]          set_pend_i,
  input  logic [NSLOT-1:0]          clr_pend_i,
  input  logic                      handler_done_i,
  output logic                      entry_o,
  output logic [VEC_W-1:0]          vector_o,
  output logic                      tail_chain_o,
  output logic [LVL_W-1:0]          exec_prio_o
);
  localparam logic [LVL_W-1:0] THREAD_LVL = '1;
  localparam int KEY_W = LVL_W + PRIO_W;

  logic [NSLOT*LVL_W-1:0]  lvl;
  logic [NSLOT*PRIO_W-1:0] sub;
  logic [NSLOT*KEY_W-1:0]  pend_key;
  logic [NSLOT-1:0] pend, act, act_after, elig, req, take_oh, retire_oh;
  logic             cur_found, rem_found, win_found, take, retiring;
  logic [IDX_W-1:0] cur_idx, rem_idx, win_idx;
  logic [LVL_W-1:0] exec_after, win_lvl;

  logic             entry_q, tail_q;
  logic [VEC_W-1:0] vec_q;

  exc_level_map #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .LVL_W(LVL_W), .GRP_W(GRP_W)) u_map (
    .prio_i (irq_prio_i),
    .group_i(prio_group_i),
    .lvl_o  (lvl),
    .sub_o  (sub)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_key
    assign pend_key[s*KEY_W +: KEY_W] = {lvl[s*LVL_W +: LVL_W], sub[s*PRIO_W +: PRIO_W]};
  end

  assign req  = {irq_i, hard_fault_i, nmi_i} | set_pend_i;
  assign elig = pend & {irq_en_i, {FIXED_SLOTS{1'b1}}};

  // handler now running
  exc_min_select #(.N(NSLOT), .KEY_W(LVL_W)) u_cur (
    .valid_i(act), .key_i(lvl), .found_o(cur_found), .idx_o(cur_idx)
  );
  assign exec_prio_o = cur_found ? lvl[cur_idx*LVL_W +: LVL_W] : THREAD_LVL;
  assign retiring    = handler_done_i && cur_found;

  always_comb begin
    retire_oh = '0;
    if (retiring) retire_oh[cur_idx] = 1'b1;
  end
  assign act_after = act & ~retire_oh;

  // level left once the retiring handler is gone
  exc_min_select #(.N(NSLOT), .KEY_W(LVL_W)) u_rem (
    .valid_i(act_after), .key_i(lvl), .found_o(rem_found), .idx_o(rem_idx)
  );
  assign exec_after = rem_found ? lvl[rem_idx*LVL_W +: LVL_W] : THREAD_LVL;

  exc_min_select #(.N(NSLOT), .KEY_W(KEY_W)) u_win (
    .valid_i(elig), .key_i(pend_key), .found_o(win_found), .idx_o(win_idx)
  );
  assign win_lvl = lvl[win_idx*LVL_W +: LVL_W];
  assign take    = win_found && (win_lvl < exec_after);

  always_comb begin
    take_oh = '0;
    if (take) take_oh[win_idx] = 1'b1;
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    exc_slot_fsm u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (req[s]),
      .clr_i   (clr_pend_i[s]),
      .take_i  (take_oh[s]),
      .retire_i(retire_oh[s]),
      .pend_o  (pend[s]),
      .act_o   (act[s])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_q <= 1'b0;
      tail_q  <= 1'b0;
      vec_q   <= '0;
    end else begin
      entry_q <= take;
      tail_q  <= take && retiring;
      if (take) vec_q <= VEC_W'(win_idx) + VEC_W'(VEC_OFFSET);
    end
  end

  assign entry_o      = entry_q;
  assign tail_chain_o = tail_q;
  assign vector_o     = vec_q;

  AST_TAIL_NEEDS_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_chain_o |-> entry_o); // R9
  AST_EXEC_TIGHTENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entry_o && !tail_chain_o) |-> (exec_prio_o < $past(exec_prio_o))); // R6
  AST_NEST_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(act) <= MAX_NEST); // R8
  AST_WIN_ELIGIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_found |-> elig[win_idx]); // R7
endmodule

// File: tb/exc_nest_ctrl_test.sv
`timescale 1ns/1ps
module exc_nest_ctrl_test;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [61:0]  irq_i = '0;
  logic [61:0]  irq_en_i = '0;
  logic [185:0] irq_prio_i = '0;
  logic [1:0]   prio_group_i = '0;
  logic         nmi_i = 1'b0;
  logic         hard_fault_i = 1'b0;
  logic [63:0]  set_pend_i = '0;
  logic [63:0]  clr_pend_i = '0;
  logic         handler_done_i = 1'b0;
  logic         entry_o, tail_chain_o;
  logic [6:0]   vector_o;
  logic [3:0]   exec_prio_o;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  exc_nest_ctrl uut (.*);

  always #2.5 clk_i = ~clk_i;

  // a, b, prio a, prio b, group, winner (0 = a, 1 = b)
  localparam int NROW = 8;
  localparam int ROWS [NROW][6] = '{
    '{0,  1,  2, 5, 0, 0},
    '{3,  9,  6, 1, 0, 1},
    '{5,  2,  4, 4, 0, 1},
    '{8,  6,  3, 2, 1, 1},
    '{4,  7,  1, 2, 2, 0},
    '{11, 12, 7, 0, 3, 1},
    '{61, 60, 0, 0, 0, 1},
    '{13, 14, 4, 3, 1, 1}
  };

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_set(int slot);
    set_pend_i[slot] = 1'b1;
    step();
    set_pend_i = '0;
  endtask

  task automatic done_pulse();
    handler_done_i = 1'b1;
    step();
    handler_done_i = 1'b0;
  endtask

  task automatic set_prio(int k, int p);
    irq_prio_i[k*3 +: 3] = 3'(p);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 entry", int'(entry_o), 0);
    chk("R1 tail", int'(tail_chain_o), 0);
    chk("R1 exec", int'(exec_prio_o), 15);

    irq_en_i = '1;
    for (int r = 0; r < NROW; r++) begin
      int a, b, w, l, wp, g;
      a = ROWS[r][0]; b = ROWS[r][1]; g = ROWS[r][4];
      w  = ROWS[r][5] ? b : a;
      l  = ROWS[r][5] ? a : b;
      wp = ROWS[r][5] ? ROWS[r][3] : ROWS[r][2];
      set_prio(a, ROWS[r][2]);
      set_prio(b, ROWS[r][3]);
      prio_group_i = 2'(g);
      set_pend_i[a+2] = 1'b1;
      set_pend_i[b+2] = 1'b1;
      step();
      set_pend_i = '0;
      step();
      chk("R7 win entry", int'(entry_o), 1);
      chk("R7 win vector", int'(vector_o), w + 4);
      chk("R6 win exec", int'(exec_prio_o), (wp >> g) + 3);
      done_pulse();
      chk("R9 loser tail", int'(tail_chain_o), 1);
      chk("R9 loser vector", int'(vector_o), l + 4);
      done_pulse();
      chk("R8 idle entry", int'(entry_o), 0);
      chk("R8 idle exec", int'(exec_prio_o), 15);
      set_prio(a, 0);
      set_prio(b, 0);
    end
    prio_group_i = '0;

    // R5 fixed ranks
    set_pend_i[0] = 1'b1; set_pend_i[1] = 1'b1; set_pend_i[2] = 1'b1;
    step();
    set_pend_i = '0;
    step();
    chk("R5 nmi vector", int'(vector_o), 2);
    chk("R5 nmi exec", int'(exec_prio_o), 1);
    step();
    chk("R5 hf held", int'(entry_o), 0);
    done_pulse();
    chk("R5 hf vector", int'(vector_o), 3);
    chk("R5 hf exec", int'(exec_prio_o), 2);
    done_pulse();
    chk("R5 prog vector", int'(vector_o), 4);
    chk("R5 prog exec", int'(exec_prio_o), 3);
    done_pulse();
    chk("R5 idle", int'(exec_prio_o), 15);

    // R4 disabled source is kept pending
    irq_en_i[5] = 1'b0;
    pulse_set(7);
    step();
    chk("R4 disabled entry", int'(entry_o), 0);
    chk("R4 disabled exec", int'(exec_prio_o), 15);
    irq_en_i[5] = 1'b1;
    step();
    chk("R4 enabled entry", int'(entry_o), 1);
    chk("R4 enabled vector", int'(vector_o), 9);
    done_pulse();

    // R3 clear discards; set wins over clear
    irq_en_i[7] = 1'b0;
    pulse_set(9);
    clr_pend_i[9] = 1'b1;
    step();
    clr_pend_i = '0;
    irq_en_i[7] = 1'b1;
    step();
    chk("R3 cleared entry", int'(entry_o), 0);
    step();
    chk("R3 cleared entry late", int'(entry_o), 0);
    irq_en_i[7] = 1'b0;
    set_pend_i[9] = 1'b1; clr_pend_i[9] = 1'b1;
    step();
    set_pend_i = '0; clr_pend_i = '0;
    irq_en_i[7] = 1'b1;
    step();
    chk("R3 set wins entry", int'(entry_o), 1);
    chk("R3 set wins vector", int'(vector_o), 11);
    done_pulse();

    // R6 / R8 nesting
    set_prio(10, 5); set_prio(11, 5); set_prio(12, 2);
    pulse_set(12);
    step();
    chk("R8 outer vector", int'(vector_o), 14);
    chk("R8 outer exec", int'(exec_prio_o), 8);
    pulse_set(13);
    step();
    chk("R6 equal no preempt", int'(entry_o), 0);
    pulse_set(14);
    step();
    chk("R8 nested entry", int'(entry_o), 1);
    chk("R8 nested vector", int'(vector_o), 16);
    chk("R8 nested tail", int'(tail_chain_o), 0);
    chk("R8 nested exec", int'(exec_prio_o), 5);
    step();
    chk("R11 single pulse", int'(entry_o), 0);
    done_pulse();
    chk("R8 return no entry", int'(entry_o), 0);
    chk("R8 return exec", int'(exec_prio_o), 8);
    done_pulse();
    chk("R9 chain entry", int'(entry_o), 1);
    chk("R9 chain tail", int'(tail_chain_o), 1);
    chk("R9 chain vector", int'(vector_o), 15);
    done_pulse();
    chk("R8 idle again", int'(exec_prio_o), 15);

    // R2 / R10 line request, re-raised while active
    set_prio(20, 1);
    irq_i[20] = 1'b1;
    step();
    irq_i[20] = 1'b0;
    step();
    chk("R2 line entry", int'(entry_o), 1);
    chk("R2 line vector", int'(vector_o), 24);
    irq_i[20] = 1'b1;
    step();
    irq_i[20] = 1'b0;
    step();
    chk("R10 no self preempt", int'(entry_o), 0);
    chk("R10 exec held", int'(exec_prio_o), 4);
    done_pulse();
    chk("R10 re-entry", int'(entry_o), 1);
    chk("R10 re-entry tail", int'(tail_chain_o), 1);
    chk("R10 re-entry vector", int'(vector_o), 24);
    done_pulse();
    chk("R10 idle entry", int'(entry_o), 0);
    chk("R10 idle exec", int'(exec_prio_o), 15);

    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule